// File: doc/BRIEF.md
# Power-Fail Reset Supervisor Sequencer

This block turns a digitized low-supply indication and an enabled watchdog expiry into an active-low processor reset. The supply comparator's output is asynchronous, so it passes through a synchronizer before it is used. While the synchronized indication says supply is below the trip point, the block asks the pad to pull the reset line low. When supply recovers, the block keeps the line low until a set number of 100 ms timebase ticks has arrived. The default is two ticks, so a tick that lands part-way through a period can never shorten the hold below one full period. An enabled watchdog expiry starts the same minimum-width pulse.

The reset output is an open-drain pull request: a 1 means pull the line low, and a 0 means let go so the weak pull-up and any other wire-ORed reset source decide the level. A lockout flag rises together with the pull request. While the flag is high, the serial register interface is refused new transactions. A transaction accepted before the lockout runs on until its done strobe. The block also forwards a registered copy of the 2-bit trip-select code to the analog comparator.

Top module: `pwr_rst_seq`

## Requirements
- R1: During and right after synchronous reset, the pull request and the lockout are 1, the transaction-busy flag and the grant are 0, and the forwarded trip code is 00.
- R2: The supply-low input passes through two flip-flops, and a third register holds the sequencer state. A level held high on it therefore sets the pull request on the third rising edge after it is applied, and the request stays set while the level stays high.
- R3: After supply recovers, the pull request stays set until HOLD_TICKS (default 2) timebase ticks have been counted. Ticks seen while supply is low are not counted. The request clears on the edge that samples the last tick.
- R4: A new low-supply indication during a hold period restarts the hold from zero.
- R5: A watchdog expiry with the enable input at 1 sets the pull request on the next edge. It then takes the same HOLD_TICKS tick hold, and a further enabled expiry during that hold restarts the count.
- R6: A watchdog expiry with the enable input at 0 has no effect on the pull request.
- R7: The lockout output equals the pull request. A transaction start presented while the lockout is 1 is not granted and leaves the busy flag at 0.
- R8: A transaction granted before the lockout keeps the busy flag at 1 through the lockout until its done strobe, and clears it on the edge after that strobe.
- R9: The forwarded trip code is the trip-select input delayed by one clock. The codes select 00 = 2.6 V, 01 = 2.9 V, 10 = 3.9 V and 11 = 4.4 V.
- R10: A start is granted only when the lockout is 0 and no transaction is busy. The grant is a one-cycle pulse on the edge after the start, and busy rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low_i | input | 1 | Asynchronous comparator output, 1 = below trip point |
| trip_sel_i | input | 2 | Trip-point select register value |
| tick_i | input | 1 | 100 ms timebase pulse, one clock wide |
| wdog_expire_i | input | 1 | Watchdog timeout pulse |
| wdog_en_i | input | 1 | Watchdog enable |
| xact_start_i | input | 1 | Serial register access start request |
| xact_done_i | input | 1 | Serial register access finished |
| rst_pull_o | output | 1 | 1 = pull the reset line low, 0 = release |
| bus_lock_o | output | 1 | New serial accesses are refused |
| xact_grant_o | output | 1 | One-cycle pulse: start accepted |
| xact_busy_o | output | 1 | An accepted access is in flight |
| trip_code_o | output | 2 | Trip code to the comparator |

## Verification
A wrong hold count, or a tick that leaks through while supply is low, shows up as the pull request falling on the wrong edge. That error is visible within one tick period of recovery. A lost low-supply or watchdog event leaves the reset line released and the lockout down, and a later start is then granted on the very next edge. A bad transaction flag shows as busy dropping before its done strobe, or as a grant pulse during lockout, so the cycle-by-cycle comparison catches it in the same cycle.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic busy;
        logic grant;
    } xact_stat_t;

    localparam int TRIP_W = 2;

    function automatic logic holding(input seq_state_t s);
        return s != SEQ_RUN;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int STAGES = 2,
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= INIT;
                else if (g == 0) chain[g] <= d_i;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pwr_hold_seq.sv
module pwr_hold_seq
    import pwr_rst_pkg::*;
#(
    parameter int HOLD_TICKS = 2,
    localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic low_s_i,
    input  logic tick_i,
    input  logic wd_go_i,
    output logic pull_o
);
    seq_state_t    state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (low_s_i) begin
            state_n = SEQ_LOW;
            cnt_n   = '0;
        end else begin
            unique case (state)
                SEQ_LOW: begin
                    state_n = SEQ_HOLD;
                    cnt_n   = '0;
                end
                SEQ_HOLD: begin
                    if (wd_go_i) cnt_n = '0;
                    else if (tick_i) begin
                        if (cnt == LAST) begin
                            state_n = SEQ_RUN;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (wd_go_i) begin
                        state_n = SEQ_HOLD;
                        cnt_n   = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    assign pull_o = holding(state);

    // R2: a synchronized low indication forces the reset request
    a_r2_low_pulls: assert property (@(posedge clk) disable iff (rst)
        low_s_i |=> pull_o);
    // R3: release only on an edge that sampled a tick
    a_r3_release_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(pull_o) |-> $past(tick_i));
    // R3: release never directly follows a low indication
    a_r3_no_release_after_low: assert property (@(posedge clk) disable iff (rst)
        $fell(pull_o) |-> !$past(low_s_i));
    // R5: enabled watchdog asserts the request
    a_r5_wdog_pulls: assert property (@(posedge clk) disable iff (rst)
        wd_go_i |=> pull_o);
endmodule

// File: rtl/pwr_bus_gate.sv
module pwr_bus_gate
    import pwr_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_i,
    input  logic       start_i,
    input  logic       done_i,
    output xact_stat_t stat_o
);
    xact_stat_t st;
    logic       accept;

    assign accept = start_i && !lock_i && !st.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.grant <= accept;
            if (accept) st.busy <= 1'b1;
            else if (done_i) st.busy <= 1'b0;
        end
    end

    assign stat_o = st;

    // R7: no grant follows a cycle with lockout active
    a_r7_no_grant_locked: assert property (@(posedge clk) disable iff (rst)
        st.grant |-> $past(!lock_i));
    // R8: busy persists until done
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !done_i) |=> st.busy);
    // R10: a busy interface never grants a second start
    a_r10_no_double_grant: assert property (@(posedge clk) disable iff (rst)
        st.busy |=> !st.grant);
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
    import pwr_rst_pkg::*;
#(
    parameter int HOLD_TICKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_low_i,
    input  logic [TRIP_W-1:0] trip_sel_i,
    input  logic              tick_i,
    input  logic              wdog_expire_i,
    input  logic              wdog_en_i,
    input  logic              xact_start_i,
    input  logic              xact_done_i,
    output logic              rst_pull_o,
    output logic              bus_lock_o,
    output logic              xact_grant_o,
    output logic              xact_busy_o,
    output logic [TRIP_W-1:0] trip_code_o
);
    logic       low_s;
    logic       pull;
    logic       wd_go;
    xact_stat_t xs;
    logic [TRIP_W-1:0] trip_q;

    pwr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d_i(supply_low_i), .q_o(low_s)
    );

    assign wd_go = wdog_expire_i && wdog_en_i;

    pwr_hold_seq #(.HOLD_TICKS(HOLD_TICKS)) u_seq (
        .clk(clk), .rst(rst), .low_s_i(low_s), .tick_i(tick_i),
        .wd_go_i(wd_go), .pull_o(pull)
    );

    pwr_bus_gate u_gate (
        .clk(clk), .rst(rst), .lock_i(pull), .start_i(xact_start_i),
        .done_i(xact_done_i), .stat_o(xs)
    );

    always_ff @(posedge clk) begin
        if (rst) trip_q <= '0;
        else     trip_q <= trip_sel_i;
    end

    assign rst_pull_o   = pull;
    assign bus_lock_o   = pull;
    assign xact_grant_o = xs.grant;
    assign xact_busy_o  = xs.busy;
    assign trip_code_o  = trip_q;

    // R9: trip code follows the select one clock later
    a_r9_trip_follow: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> trip_code_o == $past(trip_sel_i));
    // R6: a disabled watchdog cannot raise the request from run
    a_r6_wdog_masked: assert property (@(posedge clk) disable iff (rst)
        (!rst_pull_o && !wdog_en_i && !low_s) |=> !rst_pull_o);
endmodule

// File: tb/sim_pwr_rst_seq.sv
module sim_pwr_rst_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_low = 1'b0;
    logic [1:0] trip_sel = 2'b00;
    logic tick = 1'b0, wd = 1'b0, wd_en = 1'b0, start = 1'b0, done = 1'b0;
    logic pull, lock, grant, busy;
    logic [1:0] trip_code;

    int tests = 0, fails = 0;
    int tcount = 0;
    string phase = "R1";
    bit pend_wd = 0, pend_start = 0, pend_done = 0;

    always #4 clk = ~clk;

    pwr_rst_seq u0 (
        .clk(clk), .rst(rst), .supply_low_i(supply_low), .trip_sel_i(trip_sel),
        .tick_i(tick), .wdog_expire_i(wd), .wdog_en_i(wd_en),
        .xact_start_i(start), .xact_done_i(done), .rst_pull_o(pull),
        .bus_lock_o(lock), .xact_grant_o(grant), .xact_busy_o(busy),
        .trip_code_o(trip_code)
    );

    // behavioural reference model
    bit q[$] = '{1'b1, 1'b1};
    bit m_pull = 1, m_in_low = 0, m_busy = 0, m_grant = 0;
    int m_ticks = 0;
    logic [1:0] m_trip = 2'b00;

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit lowv, old_pull, old_busy;
        if (rst) begin
            q = '{1'b1, 1'b1};
            m_pull = 1; m_in_low = 0; m_ticks = 0;
            m_busy = 0; m_grant = 0; m_trip = 2'b00;
        end else begin
            old_pull = m_pull; old_busy = m_busy;
            lowv = q[1];
            q = '{supply_low, q[0]};
            if (lowv) begin
                m_in_low = 1; m_pull = 1; m_ticks = 0;
            end else if (m_in_low) begin
                m_in_low = 0; m_ticks = 0;
            end else if (m_pull) begin
                if (wd && wd_en) m_ticks = 0;
                else if (tick) begin
                    m_ticks++;
                    if (m_ticks == 2) begin m_pull = 0; m_ticks = 0; end
                end
            end else if (wd && wd_en) begin
                m_pull = 1; m_ticks = 0;
            end
            m_grant = start && !old_pull && !old_busy;
            if (m_grant) m_busy = 1;
            else if (done) m_busy = 0;
            m_trip = trip_sel;
        end
        #2;
        chk(phase, "rst_pull", pull, m_pull);
        chk("R7", "bus_lock", lock, m_pull);
        chk("R8", "busy", busy, m_busy);
        chk("R10", "grant", grant, m_grant);
        chk("R9", "trip_code", trip_code, m_trip);
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick  = (tcount % 16) == 15;
            tcount++;
            wd    = pend_wd;    pend_wd = 0;
            start = pend_start; pend_start = 0;
            done  = pend_done;  pend_done = 0;
        end
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        phase = "R1";
        cyc(3);
        @(negedge clk); rst = 0;
        chk("R1", "pull after reset", pull, 1);
        chk("R1", "busy after reset", busy, 0);
        cyc(50);
        chk("R3", "released after power-up hold", pull, 0);

        phase = "R9";
        for (int k = 0; k < 4; k++) begin
            trip_sel = 2'(k);
            cyc(2);
            chk("R9", "trip code", trip_code, k);
        end

        phase = "R10";
        pend_start = 1; cyc(2);
        chk("R10", "granted busy", busy, 1);
        pend_start = 1; cyc(3);
        phase = "R8";
        supply_low = 1; cyc(6);
        chk("R8", "busy kept under lockout", busy, 1);
        phase = "R7";
        pend_done = 1; cyc(3);
        pend_start = 1; cyc(3);
        chk("R7", "no busy while locked", busy, 0);

        phase = "R2";
        cyc(40);
        phase = "R3";
        supply_low = 0; cyc(60);
        chk("R3", "released after hold", pull, 0);

        phase = "R4";
        supply_low = 1; cyc(5); supply_low = 0; cyc(20);
        supply_low = 1; cyc(3); supply_low = 0; cyc(60);

        phase = "R6";
        wd_en = 0; pend_wd = 1; cyc(10);
        chk("R6", "disabled wdog ignored", pull, 0);
        phase = "R5";
        wd_en = 1; pend_wd = 1; cyc(20);
        pend_wd = 1; cyc(60);
        chk("R5", "released after wdog hold", pull, 0);
        pend_start = 1; cyc(2);
        pend_done = 1; cyc(3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule